// File: doc/BRIEF.md
# Pipelined Bus Memory Slave

This block is a small word-addressed register memory behind a pipelined Wishbone slave port. A master raises CYC for the length of a bus cycle and presents one request per clock on STB with direction, word address, write data and byte selects. The slave pushes back with STALL and answers every accepted request with exactly one ACK or ERR, in the order the requests were accepted. Read data comes back on the response cycle. Writes update only the bytes whose select bit is set.

A build parameter picks the response timing. The registered variant answers one clock after acceptance. The combinational variant answers in the same clock in which the request is accepted. A second group of parameters sets the back-pressure. STALL follows a rotating bit pattern, and a run-length cap limits it. Responses are suppressed whenever CYC is low, so a master that drops CYC early sees no late answers. An internal counter tracks the requests that have been accepted but not yet answered. The protocol checks use this counter.

Top module: `wb_pipe_mem`

## Requirements
- R1: ACK and ERR are never high in the same cycle.
- R2: While CYC is low, ACK and ERR are low. A response due in a cycle where CYC has dropped is discarded. STALL may be high while CYC is low.
- R3: ACK or ERR appear only for an accepted request, where accepted means CYC, STB high and STALL low at a clock edge. With nothing outstanding and no request being accepted, both stay low.
- R4: With MIN_DELAY=1 the response comes exactly one clock after acceptance and never in the accepting clock. With MIN_DELAY=0 it comes in the accepting clock itself.
- R5: STALL equals bit k of STALL_PAT, where k is the number of clock edges since reset modulo PAT_W. STALL is forced low once it has been high with CYC and STB for MAX_STALL-1 consecutive cycles, so a stalled request never waits MAX_STALL cycles.
- R6: An accepted write to an in-range address replaces byte b (bits 8b+7..8b) of the stored word with the same byte of the write data for every set bit b of SEL. Other bytes are kept.
- R7: A read ACK carries the stored word on the data output in the ACK cycle. That word includes all writes accepted earlier. In every other cycle the data output is zero.
- R8: A request whose word address is DEPTH or above is answered with ERR instead of ACK, and a write to such an address changes no stored word.
- R9: Every accepted request gets exactly one response, and responses come in acceptance order.
- R10: During and after reset ACK and ERR are low and every stored word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_i | input | 1 | Bus cycle active |
| stb_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| data_i | input | DW | Write data |
| sel_i | input | DW/8 | Byte selects, bit b selects byte b |
| stall_o | output | 1 | Back-pressure; request not taken this cycle |
| ack_o | output | 1 | Successful completion |
| err_o | output | 1 | Error completion (address out of range) |
| data_o | output | DW | Read data, valid with a read ACK |

## Verification
The bench builds two instances, both with DW=32, AW=6 and DEPTH=16, so that word addresses 16 to 63 fall out of range and alias onto stored words. One instance uses MIN_DELAY=1 and the other MIN_DELAY=0. Both instances get the same inputs. Both use STALL_PAT=8'b0111_1000 and MAX_STALL=3, which gives a raw stall run of four cycles that the cap must break after two. This lets the same request stream compare the one-clock and same-clock latencies directly. It also drives the capped back-pressure at every pattern phase and shows the late-response discard when CYC drops right after an accept.

// File: rtl/wbm_pkg.sv
`timescale 1ns/1ps
package wbm_pkg;
  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_ACK  = 2'd1,
    RSP_ERR  = 2'd2
  } rsp_e;
endpackage

// File: rtl/wbm_stall_gen.sv
`timescale 1ns/1ps
module wbm_stall_gen #(
  parameter int unsigned            PAT_W     = 8,
  parameter logic [PAT_W-1:0]       STALL_PAT = '0,
  parameter int unsigned            MAX_STALL = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_i,
  input  logic stb_i,
  output logic stall_o
);
  localparam int unsigned PTR_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;
  localparam int unsigned RUN_W = $clog2(MAX_STALL + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(PAT_W - 1);
  localparam logic [RUN_W-1:0] RUN_CAP  = RUN_W'(MAX_STALL - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
  end

  // consecutive cycles a presented request was held off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        run_q <= '0;
    else if (cyc_i && stb_i && stall_o) run_q <= run_q + 1'b1;
    else                                run_q <= '0;
  end

  assign stall_o = STALL_PAT[ptr_q] && (run_q < RUN_CAP);

  a_r5_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < RUN_W'(MAX_STALL));
endmodule

// File: rtl/wbm_store.sv
`timescale 1ns/1ps
module wbm_store #(
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 8,
  parameter int unsigned DEPTH = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW/8-1:0] sel_i,
  output logic            hit_o,
  output logic [DW-1:0]   rdata_o
);
  localparam int unsigned NB    = DW / 8;
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [DW-1:0]    merged;
  logic [IDX_W-1:0] idx;

  assign idx     = addr_i[IDX_W-1:0];
  assign hit_o   = {1'b0, addr_i} < LIMIT;
  assign rdata_o = mem_q[idx];

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign merged[8*b +: 8] = sel_i[b] ? wdata_i[8*b +: 8] : rdata_o[8*b +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_i && hit_o) begin
      mem_q[idx] <= merged;
    end
  end

  a_r8_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !hit_o) |=> $stable(rdata_o) || !$stable(addr_i));
endmodule

// File: rtl/wbm_resp.sv
`timescale 1ns/1ps
module wbm_resp
  import wbm_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter bit          MIN_DELAY = 1'b1,
  parameter int unsigned OUT_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_i,
  input  logic             acc_i,
  input  logic             we_i,
  input  logic             hit_i,
  input  logic [DW-1:0]    rdata_i,
  output logic             ack_o,
  output logic             err_o,
  output logic [DW-1:0]    data_o,
  output logic [OUT_W-1:0] out_cnt_o
);
  logic resp;
  assign resp = ack_o || err_o;

  // accepted minus answered, cleared with the bus cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_cnt_o <= '0;
    else if (!cyc_i) out_cnt_o <= '0;
    else             out_cnt_o <= out_cnt_o + OUT_W'(acc_i) - OUT_W'(resp);
  end

  if (MIN_DELAY) begin : g_reg
    rsp_e          kind_q;
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        kind_q <= RSP_NONE;
        rd_q   <= '0;
      end else begin
        kind_q <= !acc_i ? RSP_NONE : (hit_i ? RSP_ACK : RSP_ERR);
        rd_q   <= (acc_i && hit_i && !we_i) ? rdata_i : '0;
      end
    end

    // late response is dropped if the master has left the cycle
    assign ack_o  = cyc_i && (kind_q == RSP_ACK);
    assign err_o  = cyc_i && (kind_q == RSP_ERR);
    assign data_o = ack_o ? rd_q : '0;

    a_r4_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_i |=> (ack_o || err_o || !cyc_i));
    a_r3_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_o || err_o) |-> (out_cnt_o != '0));
    a_r9_single_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_cnt_o <= OUT_W'(1));
  end else begin : g_comb
    assign ack_o  = acc_i && hit_i;
    assign err_o  = acc_i && !hit_i;
    assign data_o = (ack_o && !we_i) ? rdata_i : '0;

    a_r9_nothing_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_cnt_o == '0);
  end
endmodule

// File: rtl/wb_pipe_mem.sv
`timescale 1ns/1ps
module wb_pipe_mem #(
  parameter int unsigned      DW        = 32,
  parameter int unsigned      AW        = 8,
  parameter int unsigned      DEPTH     = 32,
  parameter bit               MIN_DELAY = 1'b1,
  parameter int unsigned      PAT_W     = 8,
  parameter logic [PAT_W-1:0] STALL_PAT = '0,
  parameter int unsigned      MAX_STALL = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cyc_i,
  input  logic            stb_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  input  logic [DW/8-1:0] sel_i,
  output logic            stall_o,
  output logic            ack_o,
  output logic            err_o,
  output logic [DW-1:0]   data_o
);
  localparam int unsigned OUT_W = 2;
  localparam int unsigned CHK_W = $clog2(MAX_STALL + 1);

  logic             acc;
  logic             hit;
  logic [DW-1:0]    rdata;
  logic [OUT_W-1:0] out_cnt;

  assign acc = cyc_i && stb_i && !stall_o;

  wbm_stall_gen #(
    .PAT_W(PAT_W), .STALL_PAT(STALL_PAT), .MAX_STALL(MAX_STALL)
  ) u_stall (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(cyc_i), .stb_i(stb_i), .stall_o(stall_o)
  );

  wbm_store #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(acc && we_i), .addr_i(addr_i),
    .wdata_i(data_i), .sel_i(sel_i), .hit_o(hit), .rdata_o(rdata)
  );

  wbm_resp #(.DW(DW), .MIN_DELAY(MIN_DELAY), .OUT_W(OUT_W)) u_resp (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(cyc_i), .acc_i(acc), .we_i(we_i),
    .hit_i(hit), .rdata_i(rdata), .ack_o(ack_o), .err_o(err_o),
    .data_o(data_o), .out_cnt_o(out_cnt)
  );

  // independent watch on how long a presented request is held off
  logic [CHK_W-1:0] held_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        held_q <= '0;
    else if (cyc_i && stb_i && stall_o) held_q <= held_q + 1'b1;
    else                                held_q <= '0;
  end

  a_r1_ack_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && err_o));
  a_r2_quiet_no_cyc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_i |-> (!ack_o && !err_o));
  a_r3_no_orphan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o || err_o) |-> (out_cnt != '0) || (!MIN_DELAY && acc));
  a_r5_stall_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && stb_i && stall_o) |-> (held_q < CHK_W'(MAX_STALL - 1)));
  a_r7_data_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> (data_o == '0));
endmodule

// File: tb/sim_wb_pipe_mem.sv
`timescale 1ns/1ps
module sim_wb_pipe_mem;
  localparam int DW = 32, AW = 6, DEPTH = 16, NB = 4, MAXS = 3;
  localparam logic [7:0] PAT = 8'b0111_1000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdat = '0;
  logic [NB-1:0] sel = '0;
  logic stall0, ack0, err0, stall1, ack1, err1;
  logic [DW-1:0] dat0, dat1;

  always #2.5 clk = ~clk;

  wb_pipe_mem #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .MIN_DELAY(1'b1),
    .PAT_W(8), .STALL_PAT(PAT), .MAX_STALL(MAXS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .addr_i(addr), .data_i(wdat), .sel_i(sel), .stall_o(stall0),
    .ack_o(ack0), .err_o(err0), .data_o(dat0));

  wb_pipe_mem #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .MIN_DELAY(1'b0),
    .PAT_W(8), .STALL_PAT(PAT), .MAX_STALL(MAXS)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .addr_i(addr), .data_i(wdat), .sel_i(sel), .stall_o(stall1),
    .ack_o(ack1), .err_o(err1), .data_o(dat1));

  int checks = 0, errors = 0;
  int stall_seen = 0, run = 0, max_run = 0;
  logic [DW:0] q0[$], q1[$];
  string t0[$], t1[$];
  logic [DW-1:0] ref_mem [DEPTH];

  task automatic chk(input bit ok, input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: present request, wait out stall, push expected result
  task automatic issue(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [NB-1:0] s, input string tag, input bit to0, input bit to1);
    logic [DW:0] e;
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; addr = a; wdat = d; sel = s;
    #0.5;
    while (stall0) begin
      @(negedge clk);
      #0.5;
    end
    if (a >= AW'(DEPTH)) e = {1'b1, {DW{1'b0}}};
    else if (w) begin
      for (int b = 0; b < NB; b++)
        if (s[b]) ref_mem[a][8*b +: 8] = d[8*b +: 8];
      e = '0;
    end else e = {1'b0, ref_mem[a]};
    if (to0) begin q0.push_back(e); t0.push_back(tag); end
    if (to1) begin q1.push_back(e); t1.push_back(tag); end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      stb = 1'b0;
      #1.5;
      chk(!ack1 && !err1, "R3 u1 idle response", {ack1, err1}, '0);
      if (i > 0) chk(!ack0 && !err0, "R3 u0 idle response", {ack0, err0}, '0);
    end
  endtask

  task automatic pop_cmp(input int which, input logic a, input logic e, input logic [DW-1:0] d);
    logic [DW:0] x;
    string tg;
    chk(!(a && e), "R1 ack and err together", {a, e}, '0);
    if (which == 0) begin
      if (q0.size() == 0) begin chk(1'b0, "R3 u0 response without request", {e, d}, '0); return; end
      x = q0.pop_front(); tg = t0.pop_front();
    end else begin
      if (q1.size() == 0) begin chk(1'b0, "R3 u1 response without request", {e, d}, '0); return; end
      x = q1.pop_front(); tg = t1.pop_front();
    end
    chk({e, d} == x && (a != e), $sformatf("%s u%0d", tg, which), {e, d}, x);
  endtask

  // monitor: scoreboard pops and stall-run tracking
  always @(negedge clk) begin
    #1;
    if (rst_ni) begin
      if (cyc && stb && stall0) begin
        stall_seen++; run++;
        if (run > max_run) max_run = run;
      end else run = 0;
      if (ack0 || err0) pop_cmp(0, ack0, err0, dat0);
      if (ack1 || err1) pop_cmp(1, ack1, err1, dat1);
    end
  end

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!ack0 && !err0 && !ack1 && !err1 && dat0 == 0 && dat1 == 0,
        "R10 outputs in reset", {ack0, err0, ack1, err1}, '0);
    @(negedge clk);
    rst_ni = 1'b1;

    issue(1'b0, 6'd3, '0, 4'hF, "R10 cleared word", 1, 1);
    // byte merge
    issue(1'b1, 6'd2, 32'h1122_3344, 4'hF, "R6 write full", 1, 1);
    issue(1'b1, 6'd2, 32'hAABB_CCDD, 4'b0101, "R6 write partial", 1, 1);
    issue(1'b0, 6'd2, '0, 4'hF, "R6 merged readback", 1, 1);
    // back-to-back burst over every stall phase
    for (int i = 0; i < DEPTH; i++)
      issue(1'b1, AW'(i), (i * 32'h0101_0101) ^ 32'h0000_00A5, 4'hF, "R9 burst write", 1, 1);
    for (int i = DEPTH - 1; i >= 0; i--)
      issue(1'b0, AW'(i), '0, 4'hF, "R7 burst read", 1, 1);
    // out of range: error and no aliased write
    issue(1'b1, 6'd20, 32'hDEAD_BEEF, 4'hF, "R8 write out of range", 1, 1);
    issue(1'b0, 6'd20, '0, 4'hF, "R8 read out of range", 1, 1);
    issue(1'b0, 6'd4, '0, 4'hF, "R8 alias untouched", 1, 1);
    issue(1'b0, 6'd63, '0, 4'hF, "R8 top address", 1, 1);
    issue(1'b0, 6'd15, '0, 4'hF, "R7 last word", 1, 1);
    idle_cycles(3);

    // latency of the two variants
    issue(1'b0, 6'd5, '0, 4'hF, "R4 latency read", 1, 1);
    #0.7;
    chk(ack1 && !ack0, "R4 same-clock vs registered", {ack1, ack0}, 2'b10);
    @(negedge clk);
    stb = 1'b0;
    #1.2;
    chk(ack0 && !ack1, "R4 one clock later", {ack0, ack1}, 2'b10);
    idle_cycles(2);

    // drop CYC right after an accept: registered answer must vanish
    issue(1'b0, 6'd1, '0, 4'hF, "R2 aborted read", 0, 1);
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0;
    #1.2;
    chk(!ack0 && !err0, "R2 late response discarded", {ack0, err0}, '0);
    repeat (3) begin
      @(negedge clk);
      #1.2;
      chk(!ack0 && !err0 && !ack1 && !err1, "R2 quiet with CYC low",
          {ack0, err0, ack1, err1}, '0);
    end

    issue(1'b0, 6'd2, '0, 4'hF, "R7 read after abort", 1, 1);
    idle_cycles(3);
    @(negedge clk);
    cyc = 1'b0;
    repeat (2) @(negedge clk);

    chk(stall_seen > 0, "R5 pattern produced stalls", stall_seen, 1);
    chk(max_run == MAXS - 1, "R5 capped stall run", max_run, MAXS - 1);
    chk(q0.size() == 0, "R9 u0 all answered", q0.size(), 0);
    chk(q1.size() == 0, "R9 u1 all answered", q1.size(), 0);
    finish_run();
  end
endmodule